// File: doc/BRIEF.md
# Double-Buffered Synthesizer Divider Settings Register

This block holds the divider settings of an integer-N frequency synthesizer. It has two 20-bit stages. A staging word collects new settings through either of two load paths. The first is a one-bit serial path with its own shift clock and an active-low load window. The second is an 8-bit parallel bus with three byte-write strobes. A live word drives the divider outputs. The main divider value (7 bits), the swallow value (4 bits), the reference divider value (4 bits), the prescaler-enable bit and a 4-bit spare nibble all come from the live word.

The staging word is copied into the live word as a single transfer. This happens when the load window closes (the active-low enable rises) or when a hop strobe rises. Because of this, every divider sees its new value in the same cycle. All strobes and the serial clock are sampled in the system clock domain, and their rising edges are detected there. The serial data shifts in most significant bit first. The word layout is fixed in a shared package.

Top module: `synth_prog_reg`

## Requirements
- R1: On reset both the staging word and the live word are zero, so all outputs read zero and a commit made right after reset still yields zero.
- R2: While `ser_load_n` is low, each sampled rising edge of `ser_clk` shifts `ser_data` into bit 0 of the staging word and moves the other bits up by one. The first bit sent therefore lands in bit 19 after 20 shifts. Any earlier bits are pushed out of the top.
- R3: While `ser_load_n` is high, `ser_clk` edges leave the staging word unchanged.
- R4: Each parallel strobe writes only its own field. `wr_m` writes `par_data[7:0]` into word bits 7:0. `wr_ar` writes `par_data[7:0]` into word bits 15:8. `wr_ext` writes `par_data[3:0]` into word bits 19:16.
- R5: The word layout is as follows: main divider in bits 6:0, prescaler enable in bit 7, swallow value in bits 11:8, reference value in bits 15:12, spare nibble in bits 19:16.
- R6: The outputs stay unchanged while the staging word is loaded, and they only change on a commit.
- R7: A rising edge of `ser_load_n` copies the staging word into the live word.
- R8: A rising edge of `hop_wr` copies the staging word into the live word. A strobe that stays high causes no further copies.
- R9: If both commit strobes rise in the same cycle, exactly one copy is made, and the result equals the staging word.
- R10: The outputs change at the first clock edge at which a commit strobe is sampled high after it was sampled low, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_data | input | 1 | Serial data bit |
| ser_load_n | input | 1 | Low opens the serial load window; its rising edge commits |
| par_data | input | 8 | Parallel data byte |
| wr_m | input | 1 | Write strobe for word bits 7:0 |
| wr_ar | input | 1 | Write strobe for word bits 15:8 |
| wr_ext | input | 1 | Write strobe for word bits 19:16 |
| hop_wr | input | 1 | Hop strobe; its rising edge commits |
| m_div | output | 7 | Main divider value |
| a_div | output | 4 | Swallow counter value |
| r_div | output | 4 | Reference divider value |
| pre_en | output | 1 | Prescaler enable |
| ext_cfg | output | 4 | Spare nibble |

## Verification
The assertions check the following on every cycle:
- A detected commit copies the staging word exactly into the live word.
- Without a commit, the live word holds.
- A lone shift event moves the staging word by one bit.
- A closed load window with no byte strobe leaves the staging word alone.
- A byte strobe lands its byte in the right place.

Some properties can only be shown by the bench scenarios. These are the field placement at the output pins, the most-significant-first order over a whole frame including overlong frames, the one-cycle latency from strobe to output, and the single copy when both strobes rise together.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
   localparam int WORD_W   = 20;
   localparam int BYTE_W   = 8;
   localparam int M_W      = 7;
   localparam int A_W      = 4;
   localparam int R_W      = 4;
   localparam int X_W      = 4;
   localparam int M_LSB    = 0;
   localparam int PE_BIT   = 7;
   localparam int A_LSB    = 8;
   localparam int R_LSB    = 12;
   localparam int X_LSB    = 16;
   localparam int HI_W     = WORD_W - 2 * BYTE_W;

   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det #(
   parameter bit IDLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= IDLE;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/sp_primary.sv
module sp_primary #(
   parameter int  W         = 20,
   parameter int  BW        = 8,
   parameter bit  MSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          sdata,
   input  logic          wr_lo,
   input  logic          wr_mid,
   input  logic          wr_hi,
   input  logic [BW-1:0] pdata,
   output logic [W-1:0]  q
);
   localparam int HW = W - 2 * BW;

   logic [W-1:0] shifted;
   logic [W-1:0] nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shifted = {q[W-2:0], sdata};
      end else begin : g_lsb
         assign shifted = {sdata, q[W-1:1]};
      end
   endgenerate

   always_comb begin
      nxt = q;
      if (shift_en) nxt = shifted;
      if (wr_lo)    nxt[BW-1:0]      = pdata;
      if (wr_mid)   nxt[2*BW-1:BW]   = pdata;
      if (wr_hi)    nxt[W-1:2*BW]    = pdata[HW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/sp_secondary.sv
module sp_secondary #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         commit,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (commit) q <= d;
   end
endmodule

// File: rtl/synth_prog_reg.sv
module synth_prog_reg
   import synth_prog_pkg::*;
#(
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_load_n,
   input  logic [BYTE_W-1:0] par_data,
   input  logic              wr_m,
   input  logic              wr_ar,
   input  logic              wr_ext,
   input  logic              hop_wr,
   output logic [M_W-1:0]    m_div,
   output logic [A_W-1:0]    a_div,
   output logic [R_W-1:0]    r_div,
   output logic              pre_en,
   output logic [X_W-1:0]    ext_cfg
);
   generate
      if (HI_W < 1 || HI_W > BYTE_W) begin : g_bad_hi
         $error("synth_prog_reg: upper field width out of range");
      end
      if (M_LSB + M_W > PE_BIT || PE_BIT >= A_LSB) begin : g_bad_m
         $error("synth_prog_reg: main field overlaps prescaler bit");
      end
      if (A_LSB + A_W > R_LSB || R_LSB + R_W > X_LSB || X_LSB + X_W > WORD_W) begin : g_bad_ar
         $error("synth_prog_reg: field layout exceeds word");
      end
   endgenerate

   logic  clk_rise;
   logic  load_rise;
   logic  hop_rise;
   logic  shift_ev;
   logic  commit_ev;
   word_t prim_q;
   word_t sec_q;

   sp_edge_det #(.IDLE(1'b0)) u_clk_edge (
      .clk(clk), .rst_n(rst_n), .lvl(ser_clk), .rise(clk_rise));
   sp_edge_det #(.IDLE(1'b1)) u_load_edge (
      .clk(clk), .rst_n(rst_n), .lvl(ser_load_n), .rise(load_rise));
   sp_edge_det #(.IDLE(1'b0)) u_hop_edge (
      .clk(clk), .rst_n(rst_n), .lvl(hop_wr), .rise(hop_rise));

   assign shift_ev  = clk_rise & ~ser_load_n;
   assign commit_ev = load_rise | hop_rise;

   sp_primary #(.W(WORD_W), .BW(BYTE_W), .MSB_FIRST(MSB_FIRST)) u_prim (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_ev), .sdata(ser_data),
      .wr_lo(wr_m), .wr_mid(wr_ar), .wr_hi(wr_ext), .pdata(par_data),
      .q(prim_q));

   sp_secondary #(.W(WORD_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .commit(commit_ev), .d(prim_q), .q(sec_q));

   assign m_div   = sec_q[M_LSB +: M_W];
   assign pre_en  = sec_q[PE_BIT];
   assign a_div   = sec_q[A_LSB +: A_W];
   assign r_div   = sec_q[R_LSB +: R_W];
   assign ext_cfg = sec_q[X_LSB +: X_W];
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
   import synth_prog_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              commit_ev,
   input logic              shift_ev,
   input logic              ser_load_n,
   input logic              ser_data,
   input logic              wr_m,
   input logic              wr_ar,
   input logic              wr_ext,
   input logic [BYTE_W-1:0] par_data,
   input word_t             prim,
   input word_t             sec
);
   logic par_any;
   assign par_any = wr_m | wr_ar | wr_ext;

   p_commit_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      commit_ev |=> (sec == $past(prim)));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_ev |=> $stable(sec));

   p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_ev && !par_any) |=> (prim == {$past(prim[WORD_W-2:0]), $past(ser_data)}));

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_load_n && !par_any) |=> $stable(prim));

   p_byte_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_m |=> (prim[BYTE_W-1:0] == $past(par_data)));
endmodule

bind synth_prog_reg synth_prog_chk u_chk (
   .clk(clk), .rst_n(rst_n), .commit_ev(commit_ev), .shift_ev(shift_ev),
   .ser_load_n(ser_load_n), .ser_data(ser_data), .wr_m(wr_m), .wr_ar(wr_ar),
   .wr_ext(wr_ext), .par_data(par_data), .prim(prim_q), .sec(sec_q));

// File: tb/synth_prog_reg_test.sv
`timescale 1ns/1ps
module synth_prog_reg_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_data = 1'b0;
   logic       ser_load_n = 1'b1;
   logic [7:0] par_data = 8'h00;
   logic       wr_m = 1'b0;
   logic       wr_ar = 1'b0;
   logic       wr_ext = 1'b0;
   logic       hop_wr = 1'b0;
   logic [6:0] m_div;
   logic [3:0] a_div;
   logic [3:0] r_div;
   logic       pre_en;
   logic [3:0] ext_cfg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   synth_prog_reg uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load_n(ser_load_n), .par_data(par_data), .wr_m(wr_m), .wr_ar(wr_ar),
      .wr_ext(wr_ext), .hop_wr(hop_wr), .m_div(m_div), .a_div(a_div),
      .r_div(r_div), .pre_en(pre_en), .ext_cfg(ext_cfg));

   // Word layout per R5: spare 19:16, R 15:12, A 11:8, prescaler 7, M 6:0
   function automatic logic [19:0] outword();
      return {ext_cfg, r_div, a_div, pre_en, m_div};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic [19:0] exp, input string tag);
      logic [19:0] got;
      got = outword();
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %05h expected %05h", tag, got, exp);
      end
   endtask

   task automatic ser_bit(input logic b);
      ser_data = b;
      ser_clk  = 1'b1;
      step();
      ser_clk  = 1'b0;
      step();
   endtask

   task automatic t_reset();
      chk(20'h0, "R1 outputs after reset");
      hop_wr = 1'b1; step(); hop_wr = 1'b0; step();
      chk(20'h0, "R1 staging word cleared");
   endtask

   task automatic t_serial(input logic [19:0] w, input int extra);
      ser_load_n = 1'b0; step();
      for (int i = 0; i < extra; i++) ser_bit(i[0]);
      for (int i = 19; i >= 0; i--) ser_bit(w[i]);
   endtask

   task automatic t_serial_basic();
      logic [19:0] prev;
      logic [19:0] w;
      prev = outword();
      w = {4'h9, 4'hC, 4'h5, 1'b1, 7'h5A};
      t_serial(w, 0);
      chk(prev, "R6 outputs hold during serial load");
      ser_load_n = 1'b1; step();
      chk(w, "R2 R5 R7 serial frame committed on load close");
      checks++;
      if (m_div !== 7'h5A || pre_en !== 1'b1 || a_div !== 4'h5 || r_div !== 4'hC) begin
         errors++;
         $display("FAIL R5: fields m=%h pe=%b a=%h r=%h expected 5a 1 5 c",
                  m_div, pre_en, a_div, r_div);
      end
   endtask

   task automatic t_serial_long();
      logic [19:0] w;
      w = {4'h3, 4'h7, 4'hE, 1'b0, 7'h21};
      t_serial(w, 4);
      ser_load_n = 1'b1; step();
      chk(w, "R2 overlong frame keeps last 20 bits");
   endtask

   task automatic t_ignore();
      logic [19:0] prev;
      prev = outword();
      for (int i = 0; i < 6; i++) ser_bit(1'b1);
      hop_wr = 1'b1; step(); hop_wr = 1'b0; step();
      chk(prev, "R3 shift clock ignored with load window closed");
   endtask

   task automatic t_parallel();
      logic [19:0] prev;
      logic [19:0] w;
      prev = outword();
      par_data = 8'hB3; wr_m = 1'b1; step(); wr_m = 1'b0;
      par_data = 8'h6D; wr_ar = 1'b1; step(); wr_ar = 1'b0;
      par_data = 8'hFA; wr_ext = 1'b1; step(); wr_ext = 1'b0;
      w = 20'hA6DB3;
      chk(prev, "R6 outputs hold during parallel writes");
      hop_wr = 1'b1;
      #1;
      chk(prev, "R10 no change before sampling edge");
      step();
      chk(w, "R4 R8 R10 hop commit of parallel word");
      par_data = 8'h11; wr_m = 1'b1; step(); wr_m = 1'b0; step();
      chk(w, "R8 held hop strobe makes no new copy");
      hop_wr = 1'b0; step();
      hop_wr = 1'b1; step(); hop_wr = 1'b0;
      chk(20'hA6D11, "R4 R8 only low byte rewritten");
   endtask

   task automatic t_both();
      ser_load_n = 1'b0;
      par_data = 8'h42; wr_ar = 1'b1; step(); wr_ar = 1'b0;
      ser_load_n = 1'b1; hop_wr = 1'b1; step();
      chk(20'hA4211, "R9 simultaneous strobes give one copy");
      hop_wr = 1'b0; step();
      chk(20'hA4211, "R9 R6 stable after dual commit");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_serial_basic();
      t_serial_long();
      t_ignore();
      t_parallel();
      t_both();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule